// File: doc/BRIEF.md
# Programmable Interrupt Controller

This block gathers interrupt requests from eight fixed on-chip sources and a small group of external pins, and presents them to a processor as two request lines: a normal request and a fast request. Every source has its own enable bit and a routing bit that sends it to one output or the other. Each output is raised while any enabled, pending source routed to it is present.

External pins first pass through a two-stage synchroniser. A polarity bit can invert each pin, and a sensitivity bit selects the detection mode. In level mode the pending bit tracks the conditioned pin. In edge mode an active edge latches a sticky pending bit, which stays set until software writes a one to it. Internal sources are always treated as active-high levels.

For each output, a fixed priority encoder reports the lowest-numbered enabled pending source routed to that output. A control bit turns the encoder off: the two vector registers then return the raw masked pending set, so that software can rank the requests itself. Software reads and writes the configuration through a small word-addressed register port. Writes take effect at the clock edge; reads are combinational.

Top module: `intc_core`

## Requirements
- R1: After reset the enable, route, sense, polarity and control registers read 0, both request outputs are low, and both vector registers read 16'hFFFF.
- R2: Source numbering puts internal source k at index k (0..7) and external pin j at index 8+j. An internal source is active-high, and its pending bit follows the input one clock later.
- R3: An external pin in level mode (sense bit 0) sets its pending bit to the synchronised pin value XOR its polarity bit, with the pin passing three clock edges of delay.
- R4: An external pin in edge mode (sense bit 1) sets its pending bit on a 0-to-1 transition of the polarity-adjusted pin. The bit stays set after the pin returns inactive.
- R5: Writing the pending register (address 4) clears each edge-mode pending bit whose data bit is 1. Data bits of 0, and bits of level-mode or internal sources, have no effect.
- R6: When an active edge and a clear of the same bit fall in the same clock, the pending bit ends up set.
- R7: A polarity bit of 1 makes the pin active-low: a low level counts as active in level mode, and a falling pin edge counts as active in edge mode.
- R8: A route bit of 1 sends its source to fiq_o, and 0 sends it to irq_o. Each output is the OR of the pending, enabled sources routed to it.
- R9: A source whose enable bit is 0 affects neither output nor either vector register.
- R10: Unless bypass is set, the normal vector register (address 6) and the fast vector register (address 7) return the lowest pending, enabled index routed to that output, zero-extended, or 16'hFFFF when there is none.
- R11: When control bit 0 (bypass, address 5) is 1, each vector register returns the pending AND enable set, masked to the sources routed to that output.
- R12: Register addresses: 0 enable, 1 route, 2 sense, 3 polarity, 4 pending (read state / write-one-to-clear), 5 control, 6 normal vector, 7 fast vector. Register bits map to source indices, and external-only registers use bit j for pin j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src_i | input | 8 | Internal interrupt sources, active-high |
| ext_pin_i | input | 4 | External interrupt pins, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two functions can act in the same clock: an edge-mode pin sets its pending bit while software issues a write-one-to-clear for that same bit. The bench clears the bit first. It then raises the pin and times the clear write so that it is sampled at exactly the edge where the synchronised edge is detected. The result is judged by reading the pending register afterwards: the bit must be 1, whereas a clear-wins design would leave it at 0.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    RA_ENABLE = 3'd0,
    RA_ROUTE  = 3'd1,
    RA_SENSE  = 3'd2,
    RA_POL    = 3'd3,
    RA_PEND   = 3'd4,
    RA_CTRL   = 3'd5,
    RA_NVEC   = 3'd6,
    RA_FVEC   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/intc_pin_cond.sv
module intc_pin_cond #(
  parameter int N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] pin_i,
  input  logic [N_EXT-1:0] pol_i,
  output logic [N_EXT-1:0] lvl_o,
  output logic [N_EXT-1:0] edge_o
);
  for (genvar g = 0; g < N_EXT; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    logic s1_d, s2_d, prev_d;

    always_comb begin
      s1_d   = pin_i[g];
      s2_d   = s1_q;
      prev_d = lvl_o[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= s1_d;
        s2_q   <= s2_d;
        prev_q <= prev_d;
      end
    end

    assign lvl_o[g]  = s2_q ^ pol_i[g];
    assign edge_o[g] = lvl_o[g] & ~prev_q;

    // R4: an edge pulse lasts one cycle unless the polarity flips
    a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_o[g] && $stable(pol_i[g]) && $stable(pin_i[g])) |=> !edge_o[g] || !$stable(pol_i[g]));
  end
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int N_INT = 8,
  parameter int N_EXT = 4,
  localparam int N_SRC = N_INT + N_EXT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_INT-1:0] int_i,
  input  logic [N_EXT-1:0] lvl_i,
  input  logic [N_EXT-1:0] edge_i,
  input  logic [N_EXT-1:0] sense_i,
  input  logic [N_EXT-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q, pend_d;

  always_comb begin
    pend_d[N_INT-1:0] = int_i;
    for (int j = 0; j < N_EXT; j++) begin
      if (sense_i[j])
        pend_d[N_INT+j] = (pend_q[N_INT+j] & ~clr_i[j]) | edge_i[j];
      else
        pend_d[N_INT+j] = lvl_i[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar j = 0; j < N_EXT; j++) begin : g_chk
    // R4: sticky while no clear arrives
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[j] && pend_q[N_INT+j] && !clr_i[j]) |=> pend_q[N_INT+j]);
    // R5: clear without a new edge drops the bit
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[j] && clr_i[j] && !edge_i[j]) |=> !pend_q[N_INT+j]);
    // R6: set wins over clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[j] && clr_i[j] && edge_i[j]) |=> pend_q[N_INT+j]);
    // R3: level mode follows conditioned pin
    a_r3_level: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_i[j] |=> (pend_q[N_INT+j] == $past(lvl_i[j])));
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N = 12,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  // R10: winner is requesting and nothing lower is
  a_r10_winner: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0)));
  a_r10_none: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (req_i == '0));
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_INT = 8,
  parameter int N_EXT = 4,
  parameter int DW    = 16,
  localparam int N_SRC = N_INT + N_EXT,
  localparam int IW    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [N_SRC-1:0] pend_i,
  input  logic             nval_i,
  input  logic [IW-1:0]    nidx_i,
  input  logic             fval_i,
  input  logic [IW-1:0]    fidx_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] route_o,
  output logic [N_EXT-1:0] sense_o,
  output logic [N_EXT-1:0] pol_o,
  output logic             bypass_o,
  output logic [N_EXT-1:0] clr_o
);
  logic [N_SRC-1:0] en_q, en_d, route_q, route_d;
  logic [N_EXT-1:0] sense_q, sense_d, pol_q, pol_d;
  logic             byp_q, byp_d;
  logic             we_en, we_route, we_sense, we_pol, we_ctrl, we_pend;
  logic [DW-1:0]    nvec, fvec;
  logic             unused_wr;

  assign unused_wr = ^wr_data_i[DW-1:N_SRC];

  always_comb begin
    we_en    = wr_en_i && (wr_addr_i == RA_ENABLE);
    we_route = wr_en_i && (wr_addr_i == RA_ROUTE);
    we_sense = wr_en_i && (wr_addr_i == RA_SENSE);
    we_pol   = wr_en_i && (wr_addr_i == RA_POL);
    we_ctrl  = wr_en_i && (wr_addr_i == RA_CTRL);
    we_pend  = wr_en_i && (wr_addr_i == RA_PEND);
    en_d     = we_en    ? wr_data_i[N_SRC-1:0] : en_q;
    route_d  = we_route ? wr_data_i[N_SRC-1:0] : route_q;
    sense_d  = we_sense ? wr_data_i[N_EXT-1:0] : sense_q;
    pol_d    = we_pol   ? wr_data_i[N_EXT-1:0] : pol_q;
    byp_d    = we_ctrl  ? wr_data_i[0]         : byp_q;
    clr_o    = we_pend  ? (wr_data_i[N_SRC-1:N_INT] & sense_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      sense_q <= '0;
      pol_q   <= '0;
      byp_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      route_q <= route_d;
      sense_q <= sense_d;
      pol_q   <= pol_d;
      byp_q   <= byp_d;
    end
  end

  assign en_o     = en_q;
  assign route_o  = route_q;
  assign sense_o  = sense_q;
  assign pol_o    = pol_q;
  assign bypass_o = byp_q;

  always_comb begin
    if (byp_q) begin
      nvec = DW'(pend_i & en_q & ~route_q);
      fvec = DW'(pend_i & en_q & route_q);
    end else begin
      nvec = nval_i ? DW'(nidx_i) : '1;
      fvec = fval_i ? DW'(fidx_i) : '1;
    end
    case (rd_addr_i)
      RA_ENABLE: rd_data_o = DW'(en_q);
      RA_ROUTE:  rd_data_o = DW'(route_q);
      RA_SENSE:  rd_data_o = DW'(sense_q);
      RA_POL:    rd_data_o = DW'(pol_q);
      RA_PEND:   rd_data_o = DW'(pend_i);
      RA_CTRL:   rd_data_o = DW'(byp_q);
      RA_NVEC:   rd_data_o = nvec;
      default:   rd_data_o = fvec;
    endcase
  end

  // R5: clears reach only edge-mode pins
  a_r5_clr_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_o & ~sense_q) == '0));
endmodule

// File: rtl/intc_core.sv
module intc_core #(
  parameter int N_INT = 8,
  parameter int N_EXT = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_INT-1:0] int_src_i,
  input  logic [N_EXT-1:0] ext_pin_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int N_SRC = N_INT + N_EXT;
  localparam int IW    = $clog2(N_SRC);

  logic [N_EXT-1:0] lvl, edg, sense, pol, clr;
  logic [N_SRC-1:0] pend, en, route, nreq, freq;
  logic             bypass, nval, fval;
  logic [IW-1:0]    nidx, fidx;

  intc_pin_cond #(.N_EXT(N_EXT)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i), .pol_i(pol),
    .lvl_o(lvl), .edge_o(edg)
  );

  intc_pend #(.N_INT(N_INT), .N_EXT(N_EXT)) u_pend (
    .clk(clk), .rst_n(rst_n), .int_i(int_src_i), .lvl_i(lvl),
    .edge_i(edg), .sense_i(sense), .clr_i(clr), .pend_o(pend)
  );

  assign nreq = pend & en & ~route;
  assign freq = pend & en & route;

  intc_prio #(.N(N_SRC)) u_nprio (
    .clk(clk), .rst_n(rst_n), .req_i(nreq), .valid_o(nval), .idx_o(nidx)
  );
  intc_prio #(.N(N_SRC)) u_fprio (
    .clk(clk), .rst_n(rst_n), .req_i(freq), .valid_o(fval), .idx_o(fidx)
  );

  intc_regs #(.N_INT(N_INT), .N_EXT(N_EXT), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .pend_i(pend), .nval_i(nval), .nidx_i(nidx), .fval_i(fval), .fidx_i(fidx),
    .en_o(en), .route_o(route), .sense_o(sense), .pol_o(pol),
    .bypass_o(bypass), .clr_o(clr)
  );

  assign irq_o = |nreq;
  assign fiq_o = |freq;

  // R8/R10: each request output agrees with its encoder
  a_r8_irq_agree: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == nval);
  a_r8_fiq_agree: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == fval);
  // R8: a source never drives both outputs
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (nval && fval) |-> (nidx != fidx));
endmodule

// File: tb/sim_intc_core.sv
module sim_intc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  int_src;
  logic [3:0]  ext_pin;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        irq, fiq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  intc_core u0 (
    .clk(clk), .rst_n(rst_n), .int_src_i(int_src), .ext_pin_i(ext_pin),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .fiq_o(fiq)
  );

  typedef struct packed {
    logic [7:0]  ints;
    logic [3:0]  ext;
    logic [11:0] en;
    logic [11:0] route;
    logic [3:0]  pol;
    logic        byp;
    logic        xirq;
    logic        xfiq;
    logic [15:0] nv;
    logic [15:0] fv;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{8'h05, 4'h0, 12'hFFF, 12'h000, 4'h0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'hFFFF},
    '{8'h05, 4'h0, 12'hFFF, 12'h001, 4'h0, 1'b0, 1'b1, 1'b1, 16'h0002, 16'h0000},
    '{8'h05, 4'h0, 12'hFFE, 12'h001, 4'h0, 1'b0, 1'b1, 1'b0, 16'h0002, 16'hFFFF},
    '{8'h00, 4'h0, 12'hFFF, 12'h400, 4'h4, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'h000A},
    '{8'h80, 4'h2, 12'hFFF, 12'h080, 4'h0, 1'b0, 1'b1, 1'b1, 16'h0009, 16'h0007},
    '{8'h80, 4'h2, 12'hFFF, 12'h080, 4'h0, 1'b1, 1'b1, 1'b1, 16'h0200, 16'h0080},
    '{8'hC0, 4'h0, 12'h040, 12'h000, 4'h0, 1'b0, 1'b1, 1'b0, 16'h0006, 16'hFFFF},
    '{8'h00, 4'h0, 12'hFFF, 12'h000, 4'h0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; int_src = '0; ext_pin = '0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 fiq", 16'(fiq), 16'h0);
    for (int a = 0; a < 6; a++) begin
      if (a == 4) continue;
      rd(3'(a), v); chk("R1 cfg", v, 16'h0);
    end
    rd(3'd6, v); chk("R1 nvec", v, 16'hFFFF);
    rd(3'd7, v); chk("R1 fvec", v, 16'hFFFF);

    // Table walk: R2 R3 R7 R8 R9 R10 R11 R12
    wr(3'd2, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, 16'(TBL[i].en));
      wr(3'd1, 16'(TBL[i].route));
      wr(3'd3, 16'(TBL[i].pol));
      wr(3'd5, 16'(TBL[i].byp));
      int_src = TBL[i].ints;
      ext_pin = TBL[i].ext;
      wait_cyc(5);
      chk("R8 irq", 16'(irq), 16'(TBL[i].xirq));
      chk("R8 fiq", 16'(fiq), 16'(TBL[i].xfiq));
      rd(3'd6, v); chk("R10/R11 nvec", v, TBL[i].nv);
      rd(3'd7, v); chk("R10/R11 fvec", v, TBL[i].fv);
    end
    rd(3'd4, v); chk("R2 pend idle", v, 16'h0000);

    // R2: internal pending one clock after the input
    @(negedge clk); int_src = 8'h10;
    @(negedge clk); rd(3'd4, v); chk("R2 int latency", v, 16'h0010);
    int_src = 8'h00;
    wait_cyc(2);

    // R4: edge mode sticky (pin 0 = source 8)
    wr(3'd5, 16'h0); wr(3'd3, 16'h0); wr(3'd0, 16'hFFF); wr(3'd1, 16'h0);
    wr(3'd2, 16'h0001);
    wait_cyc(3);
    wr(3'd4, 16'h0100);
    @(negedge clk); ext_pin = 4'h1;
    wait_cyc(4); ext_pin = 4'h0;
    wait_cyc(5);
    rd(3'd4, v); chk("R4 sticky", v, 16'h0100);
    chk("R4 irq", 16'(irq), 16'h1);
    rd(3'd6, v); chk("R4 nvec", v, 16'h0008);

    // R5: zero write ignored, one write clears
    wr(3'd4, 16'h0000);
    rd(3'd4, v); chk("R5 zero write", v, 16'h0100);
    wr(3'd4, 16'h0100);
    rd(3'd4, v); chk("R5 cleared", v, 16'h0000);
    chk("R5 irq low", 16'(irq), 16'h0);

    // R5: clear has no effect on a level/internal source
    @(negedge clk); int_src = 8'h01;
    wait_cyc(2);
    wr(3'd4, 16'h0001);
    rd(3'd4, v); chk("R5 level unaffected", v, 16'h0001);
    int_src = 8'h00;
    wait_cyc(2);

    // R6: edge and clear in the same cycle
    @(negedge clk); ext_pin = 4'h1;
    @(negedge clk);
    wr(3'd4, 16'h0100);
    wait_cyc(1);
    rd(3'd4, v); chk("R6 set wins", v, 16'h0100);
    ext_pin = 4'h0;
    wait_cyc(4);
    wr(3'd4, 16'h0100);

    // R7: falling edge with polarity 1 (pin 1 = source 9)
    wr(3'd2, 16'h0002);
    @(negedge clk); ext_pin = 4'h2;
    wr(3'd3, 16'h0002);
    wait_cyc(5);
    wr(3'd4, 16'h0200);
    rd(3'd4, v); chk("R7 no edge while high", v, 16'h0000);
    @(negedge clk); ext_pin = 4'h0;
    wait_cyc(5);
    rd(3'd4, v); chk("R7 falling edge", v, 16'h0200);

    // R9: disabled source invisible
    wr(3'd0, 16'h0000);
    chk("R9 irq masked", 16'(irq), 16'h0);
    rd(3'd6, v); chk("R9 nvec masked", v, 16'hFFFF);

    done = 1;
    report();
  end
endmodule